// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block is a synchronous state machine that tracks the power state of a small microcontroller. It can be in one of six states: full-speed run, low-speed run on the subclock, low-speed sleep, watch, reset hold and hardware standby. The CPU requests a change with a one-cycle sleep strobe. At the moment of the strobe the controller reads four configuration bits (standby select, direct-transition enable, low-speed on, clock-source select) and uses them to pick the next state. An interrupt brings the low-speed sleep and watch states back to low-speed execution, not to full speed.

Two external pins act on the controller asynchronously. Both are active low, and each passes through a two-flop synchronizer before it is used. The standby pin forces hardware standby and wins over the reset pin. The reset pin turns the main clock and all peripheral clocks on at once. It keeps the CPU halted until reset has been released and the oscillator has been reported stable. The controller then issues a one-cycle pulse that starts reset exception handling. From the current state the block decodes a main-clock enable, a subclock select for the CPU, a CPU run enable and a set of peripheral clock gates.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: In full-speed run (mode code 0), a sleep strobe with all four configuration bits at 1 and the divider field at zero moves the controller to low-speed run (mode code 1) on the next clock edge.
- R2: In watch (code 3), an interrupt with low-speed on at 1 moves the controller to low-speed run. With low-speed on at 0 the interrupt leaves the mode unchanged.
- R3: In low-speed sleep (code 2), an interrupt moves the controller to low-speed run.
- R4: In low-speed run, a sleep strobe with standby select 1, direct-transition enable 0 and clock-source select 1 moves the controller to watch.
- R5: In low-speed run, a sleep strobe with standby select 0, low-speed on 1 and clock-source select 1 moves the controller to low-speed sleep.
- R6: In low-speed run, a sleep strobe with standby select 1, direct-transition enable 1, low-speed on 0 and clock-source select 1 moves the controller to full-speed run.
- R7: Any transition into low-speed run while the 3-bit divider field is non-zero is refused. The mode stays as it was, and the sticky flag `cfg_err` is set.
- R8: A sleep strobe in full-speed or low-speed run whose bit combination matches no transition leaves the mode unchanged and sets the sticky flag `illegal_flag`. Both flags are cleared while the synchronized reset pin is low.
- R9: Reset pin low (with standby high) gives reset hold (code 4): main clock on, all peripheral gates on, CPU halted. The controller moves to full-speed run only once reset is released and the oscillator has been reported stable, whichever of the two comes last. `rst_exc_start` is high for exactly the first cycle of full-speed run.
- R10: Standby pin low gives hardware standby (code 5) from any mode, even when reset is also low. In this mode every clock output and the CPU run enable are 0, and the mode is kept until the reset pin goes low.
- R11: Full-speed run enables the main clock, the CPU and all gates. Low-speed run selects the subclock and runs the CPU. Low-speed sleep and watch select the subclock with the CPU halted. All three low-speed modes leave on only the gates in `KEEP_MASK` (default bits 0 to 3: two timers and two watchdogs).
- R12: A change on either pin first shows on `mode` after the third rising clock edge following the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the controller comes out in reset hold |
| sleep_stb | input | 1 | One-cycle sleep request from the CPU |
| irq | input | 1 | Interrupt request |
| res_n | input | 1 | Reset pin, active low, asynchronous |
| stby_n | input | 1 | Standby pin, active low, asynchronous |
| osc_stable | input | 1 | Main oscillator reported stable |
| cfg_ssel | input | 1 | Standby select |
| cfg_dten | input | 1 | Direct-transition enable |
| cfg_lson | input | 1 | Low-speed on |
| cfg_css | input | 1 | Clock-source select |
| clkdiv | input | DIVW | System clock divider field |
| mode | output | 3 | Current mode code |
| main_clk_en | output | 1 | Main clock enable |
| sub_sel | output | 1 | CPU runs from the subclock |
| cpu_run | output | 1 | CPU run enable |
| per_gate | output | NPER | Peripheral clock gates |
| rst_exc_start | output | 1 | Start reset exception pulse |
| cfg_err | output | 1 | Sticky divider configuration error |
| illegal_flag | output | 1 | Sticky unmatched sleep combination |

## Verification
The case that is hardest to reach from the ports is a reset release that comes before the oscillator is stable. The bench first drives the controller into hardware standby with both pins low. It then releases standby while reset stays low, and releases reset with the oscillator still unstable. It checks that the controller stays in reset hold with no exception pulse, and only then raises the oscillator-stable indication. Both sticky flags are set beforehand by rejected sleep strobes, so the same pass also shows them being cleared by the pin reset. Checks placed two and three edges after each pin change pin down the synchronizer latency.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        MD_HIGH     = 3'd0,
        MD_SUBACT   = 3'd1,
        MD_SUBSLEEP = 3'd2,
        MD_WATCH    = 3'd3,
        MD_RSTHOLD  = 3'd4,
        MD_HWSTBY   = 3'd5
    } lpm_mode_e;

    typedef struct packed {
        logic ssel;
        logic dten;
        logic lson;
        logic css;
    } lpm_cfg_t;

    typedef struct packed {
        logic      legal;
        lpm_mode_e tgt;
    } lpm_sleep_t;

    typedef struct packed {
        logic main_clk_en;
        logic sub_sel;
        logic cpu_run;
        logic gate_all;
        logic gate_keep;
    } lpm_clk_t;

    // Target of a sleep strobe issued from a running mode.
    function automatic lpm_sleep_t sleep_target(lpm_mode_e cur, lpm_cfg_t c);
        lpm_sleep_t r;
        r.legal = 1'b0;
        r.tgt   = cur;
        if (cur == MD_HIGH) begin
            if (c.ssel && c.dten && c.lson && c.css) begin
                r.legal = 1'b1;
                r.tgt   = MD_SUBACT;
            end
        end else if (cur == MD_SUBACT && c.css) begin
            if (c.ssel && !c.dten) begin
                r.legal = 1'b1;
                r.tgt   = MD_WATCH;
            end else if (!c.ssel && c.lson) begin
                r.legal = 1'b1;
                r.tgt   = MD_SUBSLEEP;
            end else if (c.ssel && c.dten && !c.lson) begin
                r.legal = 1'b1;
                r.tgt   = MD_HIGH;
            end
        end
        return r;
    endfunction

    function automatic lpm_clk_t clk_plan(lpm_mode_e m);
        lpm_clk_t p;
        p = '0;
        case (m)
            MD_HIGH:     begin p.main_clk_en = 1'b1; p.cpu_run = 1'b1; p.gate_all = 1'b1; end
            MD_SUBACT:   begin p.sub_sel = 1'b1; p.cpu_run = 1'b1; p.gate_keep = 1'b1; end
            MD_SUBSLEEP: begin p.sub_sel = 1'b1; p.gate_keep = 1'b1; end
            MD_WATCH:    begin p.sub_sel = 1'b1; p.gate_keep = 1'b1; end
            MD_RSTHOLD:  begin p.main_clk_en = 1'b1; p.gate_all = 1'b1; end
            default:     p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int   STAGES = 2,
    parameter logic RSTVAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[i] <= RSTVAL;
            else if (i == 0)
                chain[i] <= d;
            else
                chain[i] <= chain[(i == 0) ? 0 : i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lpm_next.sv
module lpm_next
    import lpm_pkg::*;
(
    input  lpm_mode_e mode_q,
    input  logic      stby_low,
    input  logic      res_low,
    input  logic      osc_ok,
    input  logic      sleep_stb,
    input  logic      irq,
    input  lpm_cfg_t  cfg,
    input  logic      div_zero,
    output lpm_mode_e mode_d,
    output logic      set_ill,
    output logic      set_cfg,
    output logic      go_exc
);
    lpm_sleep_t slp;
    logic       want_sub;

    always_comb begin
        slp      = sleep_target(mode_q, cfg);
        mode_d   = mode_q;
        set_ill  = 1'b0;
        set_cfg  = 1'b0;
        go_exc   = 1'b0;
        want_sub = 1'b0;
        if (stby_low) begin
            mode_d = MD_HWSTBY;
        end else if (res_low) begin
            mode_d = MD_RSTHOLD;
        end else begin
            case (mode_q)
                MD_RSTHOLD: begin
                    if (osc_ok) begin
                        mode_d = MD_HIGH;
                        go_exc = 1'b1;
                    end
                end
                MD_HIGH, MD_SUBACT: begin
                    if (sleep_stb) begin
                        if (!slp.legal)
                            set_ill = 1'b1;
                        else if (slp.tgt == MD_SUBACT)
                            want_sub = 1'b1;
                        else
                            mode_d = slp.tgt;
                    end
                end
                MD_WATCH:    want_sub = irq && cfg.lson;
                MD_SUBSLEEP: want_sub = irq;
                default:     mode_d = mode_q;
            endcase
            if (want_sub) begin
                if (div_zero)
                    mode_d = MD_SUBACT;
                else
                    set_cfg = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpm_outdec.sv
module lpm_outdec
    import lpm_pkg::*;
#(
    parameter int                NPER      = 8,
    parameter logic [NPER-1:0]   KEEP_MASK = 8'h0F
) (
    input  lpm_mode_e       mode_q,
    output logic            main_clk_en,
    output logic            sub_sel,
    output logic            cpu_run,
    output logic [NPER-1:0] per_gate
);
    lpm_clk_t plan;

    always_comb begin
        plan        = clk_plan(mode_q);
        main_clk_en = plan.main_clk_en;
        sub_sel     = plan.sub_sel;
        cpu_run     = plan.cpu_run;
        if (plan.gate_all)
            per_gate = '1;
        else if (plan.gate_keep)
            per_gate = KEEP_MASK;
        else
            per_gate = '0;
    end
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int              NPER      = 8,
    parameter logic [NPER-1:0] KEEP_MASK = 8'h0F,
    parameter int              DIVW      = 3,
    parameter int              SYNC_LEN  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep_stb,
    input  logic            irq,
    input  logic            res_n,
    input  logic            stby_n,
    input  logic            osc_stable,
    input  logic            cfg_ssel,
    input  logic            cfg_dten,
    input  logic            cfg_lson,
    input  logic            cfg_css,
    input  logic [DIVW-1:0] clkdiv,
    output logic [2:0]      mode,
    output logic            main_clk_en,
    output logic            sub_sel,
    output logic            cpu_run,
    output logic [NPER-1:0] per_gate,
    output logic            rst_exc_start,
    output logic            cfg_err,
    output logic            illegal_flag
);
    logic      res_s, stby_s;
    lpm_mode_e mode_q, mode_d;
    logic      osc_seen_q;
    logic      set_ill, set_cfg, go_exc;
    lpm_cfg_t  cfg;

    assign cfg = '{ssel: cfg_ssel, dten: cfg_dten, lson: cfg_lson, css: cfg_css};

    lpm_sync #(.STAGES(SYNC_LEN), .RSTVAL(1'b1)) u_sync_res (
        .clk(clk), .rst(rst), .d(res_n), .q(res_s)
    );
    lpm_sync #(.STAGES(SYNC_LEN), .RSTVAL(1'b1)) u_sync_stby (
        .clk(clk), .rst(rst), .d(stby_n), .q(stby_s)
    );

    lpm_next u_next (
        .mode_q    (mode_q),
        .stby_low  (!stby_s),
        .res_low   (!res_s),
        .osc_ok    (osc_seen_q || osc_stable),
        .sleep_stb (sleep_stb),
        .irq       (irq),
        .cfg       (cfg),
        .div_zero  (clkdiv == '0),
        .mode_d    (mode_d),
        .set_ill   (set_ill),
        .set_cfg   (set_cfg),
        .go_exc    (go_exc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q        <= MD_RSTHOLD;
            osc_seen_q    <= 1'b0;
            rst_exc_start <= 1'b0;
            illegal_flag  <= 1'b0;
            cfg_err       <= 1'b0;
        end else begin
            mode_q        <= mode_d;
            osc_seen_q    <= (mode_q == MD_RSTHOLD) && (osc_seen_q || osc_stable);
            rst_exc_start <= go_exc;
            if (!res_s) begin
                illegal_flag <= 1'b0;
                cfg_err      <= 1'b0;
            end else begin
                if (set_ill) illegal_flag <= 1'b1;
                if (set_cfg) cfg_err      <= 1'b1;
            end
        end
    end

    lpm_outdec #(.NPER(NPER), .KEEP_MASK(KEEP_MASK)) u_out (
        .mode_q      (mode_q),
        .main_clk_en (main_clk_en),
        .sub_sel     (sub_sel),
        .cpu_run     (cpu_run),
        .per_gate    (per_gate)
    );

    assign mode = mode_q;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
    import lpm_pkg::*;
#(
    parameter int NPER = 8,
    parameter int DIVW = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      mode,
    input logic            stby_s,
    input logic            res_s,
    input logic            sleep_stb,
    input logic [DIVW-1:0] clkdiv,
    input logic            main_clk_en,
    input logic            sub_sel,
    input logic            cpu_run,
    input logic [NPER-1:0] per_gate,
    input logic            rst_exc_start,
    input logic            illegal_flag
);
    a_r10_stby_wins: assert property (@(posedge clk) disable iff (rst)
        !stby_s |=> mode == MD_HWSTBY);

    a_r10_all_off: assert property (@(posedge clk) disable iff (rst)
        mode == MD_HWSTBY |-> (per_gate == '0 && !main_clk_en && !cpu_run && !sub_sel));

    a_r9_hold_halts: assert property (@(posedge clk) disable iff (rst)
        mode == MD_RSTHOLD |-> (main_clk_en && !cpu_run && per_gate == '1));

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
        rst_exc_start |=> !rst_exc_start);

    a_r9_pulse_from_hold: assert property (@(posedge clk) disable iff (rst)
        rst_exc_start |-> ($past(mode) == MD_RSTHOLD && mode == MD_HIGH));

    a_r7_sub_needs_div0: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_SUBACT && $past(mode) != MD_SUBACT) |-> $past(clkdiv) == '0);

    a_r1_sub_from_high_by_sleep: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_SUBACT && $past(mode) == MD_HIGH) |-> $past(sleep_stb));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (illegal_flag && res_s) |=> illegal_flag);

    a_r11_one_clock_src: assert property (@(posedge clk) disable iff (rst)
        sub_sel |-> !main_clk_en);
endmodule

bind lpm_seq_ctrl lpm_seq_chk #(.NPER(NPER), .DIVW(DIVW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode          (mode),
    .stby_s        (stby_s),
    .res_s         (res_s),
    .sleep_stb     (sleep_stb),
    .clkdiv        (clkdiv),
    .main_clk_en   (main_clk_en),
    .sub_sel       (sub_sel),
    .cpu_run       (cpu_run),
    .per_gate      (per_gate),
    .rst_exc_start (rst_exc_start),
    .illegal_flag  (illegal_flag)
);

// File: tb/lpm_seq_ctrl_test.sv
module lpm_seq_ctrl_test;
    localparam int NPER = 8;
    localparam logic [NPER-1:0] KEEP = 8'h0F;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_stb = 0, irq = 0, res_n = 1, stby_n = 1, osc_stable = 0;
    logic ssel = 0, dten = 0, lson = 0, css = 0;
    logic [2:0] clkdiv = 3'd0;
    logic [2:0] mode;
    logic main_clk_en, sub_sel, cpu_run, rst_exc_start, cfg_err, illegal_flag;
    logic [NPER-1:0] per_gate;

    always #2.5 clk = ~clk;

    lpm_seq_ctrl uut (
        .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .irq(irq),
        .res_n(res_n), .stby_n(stby_n), .osc_stable(osc_stable),
        .cfg_ssel(ssel), .cfg_dten(dten), .cfg_lson(lson), .cfg_css(css),
        .clkdiv(clkdiv), .mode(mode), .main_clk_en(main_clk_en),
        .sub_sel(sub_sel), .cpu_run(cpu_run), .per_gate(per_gate),
        .rst_exc_start(rst_exc_start), .cfg_err(cfg_err),
        .illegal_flag(illegal_flag)
    );

    typedef struct {
        logic [2:0]      md;
        logic            mce, sub, run, exc, cerr, ill;
        logic [NPER-1:0] gate;
        string           req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, failures = 0;
    logic exp_ill = 0, exp_cfg = 0;
    bit done = 0;

    // Driver side: expected item built from the mode table of R11
    task automatic expect_mode(input logic [2:0] m, input logic exc, input string req);
        exp_t e;
        e.md = m; e.exc = exc; e.cerr = exp_cfg; e.ill = exp_ill; e.req = req;
        e.mce = (m == 3'd0 || m == 3'd4);
        e.sub = (m == 3'd1 || m == 3'd2 || m == 3'd3);
        e.run = (m == 3'd0 || m == 3'd1);
        e.gate = (m == 3'd0 || m == 3'd4) ? '1 : (e.sub ? KEEP : '0);
        exp_q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_sleep(input logic s, input logic d, input logic l, input logic c);
        ssel = s; dten = d; lson = l; css = c;
        sleep_stb = 1'b1;
        tick(1);
        sleep_stb = 1'b0;
    endtask

    task automatic do_irq();
        irq = 1'b1;
        tick(1);
        irq = 1'b0;
    endtask

    // Monitor: compare at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (mode !== e.md || main_clk_en !== e.mce || sub_sel !== e.sub ||
                cpu_run !== e.run || per_gate !== e.gate || rst_exc_start !== e.exc ||
                cfg_err !== e.cerr || illegal_flag !== e.ill) begin
                failures++;
                $display("FAIL %s: got mode=%0d mce=%b sub=%b run=%b gate=%h exc=%b cerr=%b ill=%b exp mode=%0d mce=%b sub=%b run=%b gate=%h exc=%b cerr=%b ill=%b",
                    e.req, mode, main_clk_en, sub_sel, cpu_run, per_gate, rst_exc_start,
                    cfg_err, illegal_flag, e.md, e.mce, e.sub, e.run, e.gate, e.exc,
                    e.cerr, e.ill);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        expect_mode(3'd4, 0, "R9 reset state hold");
        tick(2);
        expect_mode(3'd4, 0, "R9 hold without oscillator");
        osc_stable = 1'b1;
        tick(1);
        expect_mode(3'd0, 1, "R9 exit with pulse");
        tick(1);
        expect_mode(3'd0, 0, "R9 pulse single cycle");

        do_sleep(1, 1, 1, 1);
        expect_mode(3'd1, 0, "R1 high to low-speed run");
        do_sleep(0, 0, 1, 1);
        expect_mode(3'd2, 0, "R5 to low-speed sleep");
        do_sleep(1, 1, 1, 1);
        expect_mode(3'd2, 0, "R11 sleep strobe ignored in low-speed sleep");
        do_irq();
        expect_mode(3'd1, 0, "R3 irq wakes low-speed sleep");
        do_sleep(1, 0, 1, 1);
        expect_mode(3'd3, 0, "R4 to watch");
        lson = 1'b0;
        do_irq();
        expect_mode(3'd3, 0, "R2 irq ignored with low-speed off");
        lson = 1'b1;
        do_irq();
        expect_mode(3'd1, 0, "R2 irq wakes watch");
        do_sleep(1, 1, 1, 1);
        exp_ill = 1'b1;
        expect_mode(3'd1, 0, "R8 unmatched in low-speed run");
        do_sleep(1, 1, 0, 1);
        expect_mode(3'd0, 0, "R6 direct to high");
        do_sleep(1, 1, 1, 0);
        expect_mode(3'd0, 0, "R8 unmatched in high");
        clkdiv = 3'd3;
        do_sleep(1, 1, 1, 1);
        exp_cfg = 1'b1;
        expect_mode(3'd0, 0, "R7 divider blocks entry");
        clkdiv = 3'd0;

        osc_stable = 1'b0;
        stby_n = 1'b0;
        res_n = 1'b0;
        tick(2);
        expect_mode(3'd0, 0, "R12 pins not yet visible");
        tick(1);
        exp_ill = 1'b0;
        exp_cfg = 1'b0;
        expect_mode(3'd5, 0, "R10 standby wins over reset");
        stby_n = 1'b1;
        tick(2);
        expect_mode(3'd5, 0, "R12 standby release delayed");
        tick(1);
        expect_mode(3'd4, 0, "R9 reset hold after standby");
        res_n = 1'b1;
        tick(3);
        expect_mode(3'd4, 0, "R9 released before oscillator stable");
        tick(2);
        expect_mode(3'd4, 0, "R9 still waiting");
        osc_stable = 1'b1;
        tick(1);
        expect_mode(3'd0, 1, "R9 late oscillator exit");
        tick(1);
        expect_mode(3'd0, 0, "R9 pulse ends");

        stby_n = 1'b0;
        tick(3);
        expect_mode(3'd5, 0, "R10 standby from high");
        stby_n = 1'b1;
        tick(5);
        expect_mode(3'd5, 0, "R10 kept until reset pin");
        tick(1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule